// File: doc/BRIEF.md
# SIMD signed absolute-difference accumulator

This block is a packed-lane arithmetic datapath. It takes two source vectors and an accumulator vector, all `VLEN` bits wide. A 2-bit size code, given with each operation, sets how the vectors are cut into lanes. In every lane it treats the two source elements as signed two's-complement numbers, forms the magnitude of their difference and adds that magnitude to the accumulator lane. The sum wraps.

The block computes the result for all four lane widths side by side from the same operands, then picks one by the size code. The chosen vector is captured in an output register when the input strobe is high. It appears one clock later together with a one-cycle valid pulse, and stays in the register until the next strobe. No lane can be masked off, and no carry crosses from one lane into the next.

Top module: `sabd_acc`

## Requirements
- R1: The size code sets the lane width: 2'b00 gives 8-bit lanes, 2'b01 gives 16-bit lanes, 2'b10 gives 32-bit lanes and 2'b11 gives 64-bit lanes. Lane i covers bits [i*W+W-1 : i*W] of each vector.
- R2: All VLEN/W lanes take a new value on every accepted operation, with no masking.
- R3: In each lane, the difference is taken as the signed value of `src_b` minus the signed value of `src_a`, and its absolute value is used.
- R4: The magnitude is formed at full precision and then cut to its low W bits. For example, with 8-bit lanes, -128 against 127 adds 0xFF.
- R5: The new lane value is the old accumulator lane plus the cut magnitude, modulo 2^W, with no saturation.
- R6: No carry crosses a lane boundary, for every size code.
- R7: `out_valid` is high for exactly the one cycle after a cycle with `in_valid` high, and `acc_out` shows that operation's result. While `in_valid` is low, `acc_out` does not change.
- R8: A synchronous active-high `rst` clears `acc_out` and `out_valid` to zero.
- R9: When `src_a` equals `src_b`, the result equals `acc_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| size_code | input | 2 | Lane width select |
| src_a | input | VLEN | First source vector (subtrahend) |
| src_b | input | VLEN | Second source vector (minuend) |
| acc_in | input | VLEN | Accumulator lanes |
| out_valid | output | 1 | Result valid pulse |
| acc_out | output | VLEN | Updated accumulator |

## Verification
Equal operands show whether any term leaks into the accumulator when the difference is zero. The most negative value against the most positive value, tried in both orders, shows whether the difference is signed, whether its sign is handled and whether the magnitude is cut to the lane width. An accumulator set to all ones with a magnitude of one in every lane shows whether carries stay inside their lanes and whether the sum wraps. Random vectors at every size code, checked against a reference model in the bench, show whether the size code selects the right lane boundaries.

// File: rtl/sabd_acc.sv
module sabd_acc #(
  parameter int VLEN = 128
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [1:0]      size_code,
  input  logic [VLEN-1:0] src_a,
  input  logic [VLEN-1:0] src_b,
  input  logic [VLEN-1:0] acc_in,
  output logic            out_valid,
  output logic [VLEN-1:0] acc_out
);
  localparam int NSZ = 4;

  logic [VLEN-1:0] res [NSZ];
  logic [VLEN-1:0] next_acc;

  for (genvar s = 0; s < NSZ; s++) begin : g_size
    localparam int W = 8 << s;
    localparam int N = VLEN / W;
    for (genvar l = 0; l < N; l++) begin : g_lane
      logic signed [W:0] ea, eb, dd;
      logic [W-1:0] mag;
      assign ea  = {src_a[l*W+W-1], src_a[l*W +: W]};
      assign eb  = {src_b[l*W+W-1], src_b[l*W +: W]};
      assign dd  = eb - ea;
      assign mag = dd[W] ? ('0 - dd[W-1:0]) : dd[W-1:0];
      assign res[s][l*W +: W] = acc_in[l*W +: W] + mag;
    end
  end

  assign next_acc = res[size_code];

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      acc_out   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) acc_out <= next_acc;
    end
  end
endmodule

module sabd_acc_chk #(
  parameter int VLEN = 128
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic [1:0]      size_code,
  input logic [VLEN-1:0] src_a,
  input logic [VLEN-1:0] src_b,
  input logic [VLEN-1:0] acc_in,
  input logic            out_valid,
  input logic [VLEN-1:0] acc_out
);
  logic [7:0] b0_mag;
  assign b0_mag = ($signed(src_b[7:0]) >= $signed(src_a[7:0])) ?
                  (src_b[7:0] - src_a[7:0]) : (src_a[7:0] - src_b[7:0]);

  assert_reset_R8: assert property (@(posedge clk)
    rst |=> (!out_valid && acc_out == '0));

  assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid));

  assert_valid_follow_R7: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(acc_out));

  assert_equal_R9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && src_a == src_b) |=> acc_out == $past(acc_in));

  assert_byte_lane_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && size_code == 2'b00) |=> acc_out[7:0] == $past(acc_in[7:0] + b0_mag));
endmodule

bind sabd_acc sabd_acc_chk #(.VLEN(VLEN)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .size_code(size_code),
  .src_a(src_a), .src_b(src_b), .acc_in(acc_in),
  .out_valid(out_valid), .acc_out(acc_out)
);

// File: tb/sabd_acc_tb.sv
module sabd_acc_tb;
  localparam int VLEN = 128;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst = 1, in_valid = 0;
  logic [1:0] size_code = 0;
  logic [VLEN-1:0] src_a = 0, src_b = 0, acc_in = 0;
  logic out_valid;
  logic [VLEN-1:0] acc_out;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sabd_acc #(.VLEN(VLEN)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .size_code(size_code),
    .src_a(src_a), .src_b(src_b), .acc_in(acc_in),
    .out_valid(out_valid), .acc_out(acc_out)
  );

  function automatic logic [VLEN-1:0] ref_calc(input logic [VLEN-1:0] a, b, c,
                                                input logic [1:0] sz);
    int w = 8 << sz;
    logic [VLEN-1:0] out = '0;
    logic [VLEN-1:0] mask = (VLEN'(1) << w) - 1;
    if (w == VLEN) mask = '1;
    for (int i = 0; i < VLEN / w; i++) begin
      logic [VLEN-1:0] ea = (a >> (i*w)) & mask;
      logic [VLEN-1:0] eb = (b >> (i*w)) & mask;
      logic [VLEN-1:0] ec = (c >> (i*w)) & mask;
      logic [VLEN-1:0] d;
      if (ea[w-1]) ea = ea | ~mask;
      if (eb[w-1]) eb = eb | ~mask;
      d = eb - ea;
      if (d[VLEN-1]) d = -d;
      out = out | (((ec + d) & mask) << (i*w));
    end
    return out;
  endfunction

  task automatic check(input string req, input logic [VLEN-1:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input string req, input logic [VLEN-1:0] a, b, c,
                       input logic [1:0] sz);
    logic [VLEN-1:0] exp = ref_calc(a, b, c, sz);
    @(negedge clk);
    src_a = a; src_b = b; acc_in = c; size_code = sz; in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    check({req, " valid"}, VLEN'(out_valid), VLEN'(1));
    check(req, acc_out, exp);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R8 valid", VLEN'(out_valid), '0);
    check("R8 data", acc_out, '0);
  endtask

  task automatic t_equal;
    for (int s = 0; s < 4; s++)
      apply("R9", {4{32'hDEAD_BEEF}}, {4{32'hDEAD_BEEF}}, {4{32'h1234_5678}}, 2'(s));
  endtask

  task automatic t_extremes;
    apply("R4 size0", {16{8'h80}}, {16{8'h7F}}, '0, 2'b00);
    check("R4 byte 0xFF", acc_out, {16{8'hFF}});
    apply("R3 size0 rev", {16{8'h7F}}, {16{8'h80}}, '0, 2'b00);
    check("R3 byte order", acc_out, {16{8'hFF}});
    apply("R3 size0 neg", {16{8'hFB}}, {16{8'h03}}, '0, 2'b00);
    check("R3 -5 vs 3 is 8", acc_out, {16{8'h08}});
    apply("R4 size1", {8{16'h8000}}, {8{16'h7FFF}}, '0, 2'b01);
    apply("R4 size2", {4{32'h7FFF_FFFF}}, {4{32'h8000_0000}}, '0, 2'b10);
    apply("R4 size3", {2{64'h8000_0000_0000_0000}}, {2{64'h7FFF_FFFF_FFFF_FFFF}}, '0, 2'b11);
    check("R4 dword", acc_out, '1);
  endtask

  task automatic t_wrap;
    for (int s = 0; s < 4; s++) begin
      int w = 8 << s;
      logic [VLEN-1:0] one = '0;
      for (int i = 0; i < VLEN / w; i++) one[i*w] = 1'b1;
      apply("R6 R5 wrap", '0, one, '1, 2'(s));
      check("R6 no carry", acc_out, '0);
    end
  endtask

  task automatic t_sizes;
    logic [VLEN-1:0] a = 128'h0100_0000_0000_00FF_0000_0001_0000_0080;
    logic [VLEN-1:0] b = 128'h00FF_0000_0001_0000_8000_0000_0080_0000;
    for (int s = 0; s < 4; s++) apply("R1 R2 sizes", a, b, 128'h5, 2'(s));
  endtask

  task automatic t_random;
    for (int n = 0; n < 40; n++) begin
      logic [VLEN-1:0] a = {$urandom, $urandom, $urandom, $urandom};
      logic [VLEN-1:0] b = {$urandom, $urandom, $urandom, $urandom};
      logic [VLEN-1:0] c = {$urandom, $urandom, $urandom, $urandom};
      apply("R2 R5 random", a, b, c, 2'(n % 4));
    end
  endtask

  task automatic t_hold;
    logic [VLEN-1:0] keep;
    apply("R7 op", {16{8'h10}}, {16{8'h20}}, '0, 2'b00);
    keep = acc_out;
    src_a = '1; src_b = '0; acc_in = '1;
    @(negedge clk);
    check("R7 pulse low", VLEN'(out_valid), '0);
    check("R7 hold", acc_out, keep);
    @(negedge clk);
    check("R7 hold2", acc_out, keep);
  endtask

  task automatic t_reset_mid;
    apply("R8 pre", {16{8'h01}}, {16{8'h09}}, '0, 2'b00);
    rst = 1;
    @(negedge clk);
    rst = 0;
    check("R8 clear", acc_out, '0);
    check("R8 clear valid", VLEN'(out_valid), '0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst = 0;
    t_reset();
    t_equal();
    t_extremes();
    t_wrap();
    t_sizes();
    t_random();
    t_hold();
    t_reset_mid();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule